// File: doc/BRIEF.md
# Registered DIMM Mode-Register Write Wrapper

This block sits between a command requester and the DRAM command bus. A requester hands it one mode-register-set (MRS) write over a valid/ready request carrying the mode-register address and bank. When the channel holds registered DIMMs, the block does not issue that MRS alone. It surrounds it with register-control writes (RCW). Before the MRS, the first RCW turns address inversion off and the second moves the command bus to slow 3T timing. After the MRS, one RCW puts timing back to 1T and a last one turns inversion back on.

Some registered DIMMs perform either of these steps on their own. One configuration bit removes both inversion writes and another removes both timing writes. Both bits are 0 after reset, so the full five-command sequence runs by default. Consecutive commands are spaced by a programmable gap of at least 8 clocks. A one-cycle done pulse marks the end of each sequence.

The sequencer has four states. IDLE goes to ISSUE on acceptance. ISSUE goes to GAP when a later step is enabled and to DONE when none is. GAP goes back to ISSUE when the gap timer expires. DONE always goes to IDLE.

Top module: `rdimm_mrs_wrap`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0, cmd_type is 0 and seq_done is 0.
- R2: A request is taken only in a cycle where req_valid and req_ready are both 1. req_ready is 1 only while idle. It stays 0 from acceptance through the done cycle and returns to 1 in the cycle after it.
- R3: The first command of a sequence appears in the cycle right after acceptance.
- R4: With cfg_rdimm=1 and both skip bits 0, five commands are issued in a fixed order. cmd_type encodes the command as 1 for RCW and 2 for MRS. An RCW carries the control-word number on cmd_addr and its value on cmd_data. The order is: RCW word 0 with data 1 (inversion off), RCW word 2 with data 1 (3T on), MRS with cmd_addr equal to the request address and cmd_data equal to the request bank, RCW word 2 with data 0 (back to 1T), and RCW word 0 with data 0 (inversion on).
- R5: With cfg_skip_inv=1, both word-0 writes are left out and the remaining commands keep their relative order.
- R6: With cfg_skip_timing=1, both word-2 writes are left out and the remaining commands keep their relative order.
- R7: With cfg_rdimm=0, only the MRS is issued, whatever the skip bits are.
- R8: Consecutive commands of one sequence are exactly max(cfg_gap, 8) cycles apart.
- R9: seq_done is 1 for exactly one cycle, the cycle after the final command.
- R10: Configuration is sampled at acceptance. Changes to the config inputs, and requests presented while busy, have no effect on the running sequence and are not accepted.
- R11: In any cycle without a command, cmd_valid is 0 and cmd_type is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | MRS request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W | Mode-register address payload |
| req_bank | input | BANK_W | Mode-register bank payload |
| cfg_rdimm | input | 1 | Channel holds registered DIMMs |
| cfg_skip_inv | input | 1 | Omit both inversion control writes |
| cfg_skip_timing | input | 1 | Omit both 3T/1T control writes |
| cfg_gap | input | GAP_W | Command spacing in clocks (minimum 8) |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_type | output | 2 | 0 none, 1 RCW, 2 MRS |
| cmd_addr | output | ADDR_W | Control-word number or MRS address |
| cmd_data | output | DATA_W | Control-word value or MRS bank |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Several properties are checked on every cycle. No command is issued while the block is ready. The first command follows acceptance immediately. Commands within one sequence are never closer than 8 cycles. Every done pulse lasts one cycle, follows a command, and ends a sequence that held exactly one MRS. The exact command order, the field encodings, each skip combination, the precise spacing for a given gap value, and the immunity to mid-sequence config changes depend on the configuration. Only the bench's sweep over all eight config combinations and several gap values shows those.

// File: rtl/rdimm_mrs_pkg.sv
package rdimm_mrs_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RCW  = 2'd1,
        CMD_MRS  = 2'd2
    } cmd_kind_e;

    // Step order is behavioural: it is the issue order on the bus.
    typedef enum logic [2:0] {
        STEP_INV_OFF  = 3'd0,
        STEP_SLOW_ON  = 3'd1,
        STEP_MODE     = 3'd2,
        STEP_SLOW_OFF = 3'd3,
        STEP_INV_ON   = 3'd4
    } step_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    localparam int NUM_STEPS   = 5;
    localparam int MIN_GAP     = 8;
    localparam int WORD_INV    = 0;
    localparam int WORD_TIMING = 2;

endpackage

// File: rtl/mrs_step_pick.sv
module mrs_step_pick
    import rdimm_mrs_pkg::*;
(
    input  logic  rdimm,
    input  logic  skip_inv,
    input  logic  skip_timing,
    input  step_e cur,
    output step_e first_step,
    output step_e next_step,
    output logic  has_next
);

    logic [NUM_STEPS-1:0] mask;

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_mask
        if (g == int'(STEP_MODE)) begin : g_mode
            assign mask[g] = 1'b1;
        end else if (g == int'(STEP_INV_OFF) || g == int'(STEP_INV_ON)) begin : g_inv
            assign mask[g] = rdimm & ~skip_inv;
        end else begin : g_tim
            assign mask[g] = rdimm & ~skip_timing;
        end
    end

    always_comb begin
        first_step = STEP_MODE;
        next_step  = STEP_MODE;
        has_next   = 1'b0;
        for (int i = NUM_STEPS - 1; i >= 0; i--) begin
            if (mask[i]) begin
                first_step = step_e'(3'(i));
            end
            if (mask[i] && (i > int'(cur))) begin
                next_step = step_e'(3'(i));
                has_next  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mrs_gap_timer.sv
module mrs_gap_timer
    import rdimm_mrs_pkg::*;
#(
    parameter int GAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [GAP_W-1:0] gap,
    output logic             expired
);

    logic [GAP_W-1:0] eff_gap;
    logic [GAP_W-1:0] cnt_q;

    // An issue cycle plus (eff_gap - 1) wait cycles spans eff_gap clocks.
    always_comb begin
        eff_gap = (gap < GAP_W'(MIN_GAP)) ? GAP_W'(MIN_GAP) : gap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= eff_gap - GAP_W'(2);
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - GAP_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/mrs_cmd_enc.sv
module mrs_cmd_enc
    import rdimm_mrs_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3,
    parameter int DATA_W = 4
) (
    input  logic              active,
    input  step_e             step,
    input  logic [ADDR_W-1:0] mrs_addr,
    input  logic [BANK_W-1:0] mrs_bank,
    output cmd_kind_e         kind,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    always_comb begin
        kind = CMD_NONE;
        addr = '0;
        data = '0;
        if (active) begin
            unique case (step)
                STEP_INV_OFF: begin
                    kind = CMD_RCW;
                    addr = ADDR_W'(WORD_INV);
                    data = DATA_W'(1);
                end
                STEP_SLOW_ON: begin
                    kind = CMD_RCW;
                    addr = ADDR_W'(WORD_TIMING);
                    data = DATA_W'(1);
                end
                STEP_MODE: begin
                    kind = CMD_MRS;
                    addr = mrs_addr;
                    data = DATA_W'(mrs_bank);
                end
                STEP_SLOW_OFF: begin
                    kind = CMD_RCW;
                    addr = ADDR_W'(WORD_TIMING);
                    data = '0;
                end
                STEP_INV_ON: begin
                    kind = CMD_RCW;
                    addr = ADDR_W'(WORD_INV);
                    data = '0;
                end
                default: begin
                    kind = CMD_NONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/rdimm_mrs_wrap.sv
module rdimm_mrs_wrap
    import rdimm_mrs_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3,
    parameter int DATA_W = 4,
    parameter int GAP_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              cfg_rdimm,
    input  logic              cfg_skip_inv,
    input  logic              cfg_skip_timing,
    input  logic [GAP_W-1:0]  cfg_gap,
    output logic              cmd_valid,
    output logic [1:0]        cmd_type,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              seq_done
);

    seq_state_e state_q, state_d;

    logic              accept;
    logic              idle;
    logic [ADDR_W-1:0] lat_addr;
    logic [BANK_W-1:0] lat_bank;
    logic              lat_rdimm, lat_skip_inv, lat_skip_tim;
    logic [GAP_W-1:0]  lat_gap;
    step_e             cur_step;

    logic              pk_rdimm, pk_skip_inv, pk_skip_tim;
    step_e             first_step, next_step;
    logic              has_next;
    logic              gap_expired;
    cmd_kind_e         enc_kind;

    assign idle   = (state_q == ST_IDLE);
    assign accept = req_valid && idle;

    // While idle the picker looks at the live config; afterwards at the copy.
    assign pk_rdimm    = idle ? cfg_rdimm       : lat_rdimm;
    assign pk_skip_inv = idle ? cfg_skip_inv    : lat_skip_inv;
    assign pk_skip_tim = idle ? cfg_skip_timing : lat_skip_tim;

    mrs_step_pick u_pick (
        .rdimm       (pk_rdimm),
        .skip_inv    (pk_skip_inv),
        .skip_timing (pk_skip_tim),
        .cur         (cur_step),
        .first_step  (first_step),
        .next_step   (next_step),
        .has_next    (has_next)
    );

    mrs_gap_timer #(.GAP_W(GAP_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    ((state_q == ST_ISSUE) && has_next),
        .tick    (state_q == ST_GAP),
        .gap     (lat_gap),
        .expired (gap_expired)
    );

    mrs_cmd_enc #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_enc (
        .active   (state_q == ST_ISSUE),
        .step     (cur_step),
        .mrs_addr (lat_addr),
        .mrs_bank (lat_bank),
        .kind     (enc_kind),
        .addr     (cmd_addr),
        .data     (cmd_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: state_d = has_next ? ST_GAP : ST_DONE;
            ST_GAP:   if (gap_expired) state_d = ST_ISSUE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture and step tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr     <= '0;
            lat_bank     <= '0;
            lat_rdimm    <= 1'b0;
            lat_skip_inv <= 1'b0;
            lat_skip_tim <= 1'b0;
            lat_gap      <= '0;
            cur_step     <= STEP_MODE;
        end else if (accept) begin
            lat_addr     <= req_addr;
            lat_bank     <= req_bank;
            lat_rdimm    <= cfg_rdimm;
            lat_skip_inv <= cfg_skip_inv;
            lat_skip_tim <= cfg_skip_timing;
            lat_gap      <= cfg_gap;
            cur_step     <= first_step;
        end else if (state_q == ST_ISSUE && has_next) begin
            cur_step     <= next_step;
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        cmd_valid = 1'b0;
        seq_done  = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: cmd_valid = 1'b1;
            ST_GAP:   ;
            ST_DONE:  seq_done  = 1'b1;
            default:  ;
        endcase
        cmd_type = enc_kind;
    end

endmodule

// File: rtl/rdimm_mrs_wrap_chk.sv
module rdimm_mrs_wrap_chk
    import rdimm_mrs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       cmd_valid,
    input logic [1:0] cmd_type,
    input logic       seq_done
);

    logic [7:0] since_cmd;
    logic       in_seq;
    logic [1:0] mrs_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_cmd <= '0;
            in_seq    <= 1'b0;
            mrs_seen  <= '0;
        end else begin
            if (cmd_valid) since_cmd <= 8'd1;
            else if (since_cmd < 8'(MIN_GAP)) since_cmd <= since_cmd + 8'd1;

            if (seq_done) in_seq <= 1'b0;
            else if (cmd_valid) in_seq <= 1'b1;

            if (req_valid && req_ready) mrs_seen <= '0;
            else if (cmd_valid && cmd_type == 2'(CMD_MRS) && mrs_seen != 2'd3)
                mrs_seen <= mrs_seen + 2'd1;
        end
    end

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || seq_done) |-> !req_ready);

    // R3
    first_cmd_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> cmd_valid);

    // R8
    min_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && in_seq) |-> (since_cmd >= 8'(MIN_GAP)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    // R9
    done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> $past(cmd_valid));

    // R4
    one_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (mrs_seen == 2'd1));

    // R11
    idle_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd_type == 2'd0));

endmodule

bind rdimm_mrs_wrap rdimm_mrs_wrap_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_type  (cmd_type),
    .seq_done  (seq_done)
);

// File: tb/sim_rdimm_mrs_wrap.sv
module sim_rdimm_mrs_wrap;

    localparam int ADDR_W = 14;
    localparam int BANK_W = 3;
    localparam int DATA_W = 4;
    localparam int GAP_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [BANK_W-1:0] req_bank = '0;
    logic              cfg_rdimm = 1'b0;
    logic              cfg_skip_inv = 1'b0;
    logic              cfg_skip_timing = 1'b0;
    logic [GAP_W-1:0]  cfg_gap = '0;
    logic              cmd_valid;
    logic [1:0]        cmd_type;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              seq_done;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    rdimm_mrs_wrap #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .GAP_W(GAP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_bank(req_bank), .cfg_rdimm(cfg_rdimm),
        .cfg_skip_inv(cfg_skip_inv), .cfg_skip_timing(cfg_skip_timing), .cfg_gap(cfg_gap),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .seq_done(seq_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input bit rd, input bit sinv, input bit stim, input int gap,
                           input logic [ADDR_W-1:0] a, input logic [BANK_W-1:0] b);
        int    n = 0;
        int    ek[5];
        int    ea[5];
        int    ed[5];
        int    geff;
        int    donec;
        string tag;
        bit    e_inv, e_tim;
        e_inv = rd && !sinv;
        e_tim = rd && !stim;
        if (!rd)       tag = "R7";
        else if (sinv) tag = "R5";
        else if (stim) tag = "R6";
        else           tag = "R4";
        if (e_inv) begin ek[n] = 1; ea[n] = 0; ed[n] = 1; n++; end
        if (e_tim) begin ek[n] = 1; ea[n] = 2; ed[n] = 1; n++; end
        ek[n] = 2; ea[n] = int'(a); ed[n] = int'(b); n++;
        if (e_tim) begin ek[n] = 1; ea[n] = 2; ed[n] = 0; n++; end
        if (e_inv) begin ek[n] = 1; ea[n] = 0; ed[n] = 0; n++; end
        geff  = (gap < 8) ? 8 : gap;
        donec = 1 + (n - 1) * geff + 1;

        @(negedge clk);
        cfg_rdimm = rd; cfg_skip_inv = sinv; cfg_skip_timing = stim;
        cfg_gap = GAP_W'(gap); req_addr = a; req_bank = b; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
        @(posedge clk);
        for (int c = 1; c <= donec + 1; c++) begin
            int k;
            @(negedge clk);
            if (c == 1) req_valid = 1'b0;
            if (c == 2) begin
                // R10: disturb inputs while busy
                req_valid = 1'b1; req_addr = ~a; req_bank = ~b;
                cfg_rdimm = !rd; cfg_skip_inv = !sinv; cfg_skip_timing = !stim;
                cfg_gap = (gap < 8) ? GAP_W'(31) : GAP_W'(0);
            end
            k = -1;
            if (((c - 1) % geff) == 0 && ((c - 1) / geff) < n) k = (c - 1) / geff;
            if (k == 0) chk(cmd_valid == 1'b1, "R3 first command", int'(cmd_valid), 1);
            chk(cmd_valid == (k >= 0), "R8 R10 command spacing", int'(cmd_valid), int'(k >= 0));
            if (k >= 0 && cmd_valid) begin
                chk(int'(cmd_type) == ek[k], tag, int'(cmd_type), ek[k]);
                chk(int'(cmd_addr) == ea[k], tag, int'(cmd_addr), ea[k]);
                chk(int'(cmd_data) == ed[k], tag, int'(cmd_data), ed[k]);
            end else if (k < 0) begin
                chk(cmd_type == 2'd0, "R11 idle type", int'(cmd_type), 0);
            end
            chk(seq_done == (c == donec), "R9 done pulse", int'(seq_done), int'(c == donec));
            chk(req_ready == (c > donec), "R2 R10 ready", int'(req_ready), int'(c > donec));
            if (c == donec) begin
                req_valid = 1'b0;
                cfg_rdimm = rd; cfg_skip_inv = sinv; cfg_skip_timing = stim;
            end
        end
        // R10: the busy-time request must not have been taken
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R10 no stray sequence", int'(cmd_valid), 0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int gaps[6] = '{0, 7, 8, 9, 20, 31};
        repeat (3) @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R1 no command in reset", int'(cmd_valid), 0);
        chk(cmd_type == 2'd0, "R1 type in reset", int'(cmd_type), 0);
        chk(seq_done == 1'b0, "R1 done in reset", int'(seq_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1 && cmd_valid == 1'b0, "R1 after reset",
            int'({req_ready, cmd_valid}), 2);
        for (int cf = 0; cf < 8; cf++) begin
            for (int gi = 0; gi < 6; gi++) begin
                run_seq(cf[2], cf[1], cf[0], gaps[gi],
                        ADDR_W'(cf * 1000 + gaps[gi] * 37 + 1), BANK_W'(cf + gi));
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule